// File: doc/BRIEF.md
# System Clock Source Selector with Power-of-Two Postscaler

This block chooses which of several free-running candidate clocks drives the system, then divides that clock by a power of two. At reset a 3-bit strap code fixes both the starting source and the starting division. The strap code is held stable by the chip. At run time, software uses a small write port to request another source or a new division ratio. It reads back the active source code, the active divide code and a ready flag.

A source change is a four-phase handshake. First, the enable of the current source is withdrawn. The controller waits until the gate of that source has closed on a falling edge in its own domain. Only then does it raise the enable of the new source. The new source must give two synchronised edges before its gate opens. At no time do two gates stand open. The clock fed to the postscaler never carries a shortened pulse. The postscaler restarts from zero when the source is switched and when the divide code changes, so its first output period is complete.

Source codes: `000` and `110` select the fast internal source (index 0), `101` selects the slow source (index 1), `111` selects the external source (index 2) and `010` selects the auxiliary source (index 3). Write port: `wr_sel=0` writes the source register from `wr_data[2:0]`. `wr_sel=1` writes the divide register from `wr_data[3:0]`.

Top module: `clksel_top`

## Requirements
- R1: Reset strap code `110` selects source index 0 with divide code 6 (1:64). Status reads `110`/6. `stat_ready` is low during reset and rises once the source is running.
- R2: Reset strap code `000` selects source index 0 with divide code 0 (1:1). Any strap code outside the five valid codes behaves as `000`, and the status reads `000`.
- R3: Divide codes 0 to 9 give a `sys_clk` period of the source period times 2^code. Codes 10 to 15 give 1:512.
- R4: Writing a valid source code that differs from the active one drops `stat_ready` in the next cycle. When the new source runs, `stat_ready` returns high and `stat_src` shows the new code.
- R5: The five valid codes map to source indices as listed above. A write of any other source code changes nothing: status, ready and output period are unchanged.
- R6: At most one source gate is open at any time. A new gate is requested only after the old gate is seen closed.
- R7: Source writes made while a switch is in progress (`stat_ready` low) are ignored. A write of the active code starts no switch.
- R8: The postscaler counter never passes half the ratio. It restarts on a source switch and on a divide change.
- R9: A divide write is accepted at any time, and `stat_div` shows it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Control and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Candidate clocks, index 0 fast, 1 slow, 2 external, 3 auxiliary |
| cfg_rst_src | input | 3 | Reset strap source code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = source register, 1 = divide register |
| wr_data | input | 4 | Write data |
| sys_clk | output | 1 | Divided system clock |
| stat_src | output | 3 | Active source code |
| stat_div | output | 4 | Active divide code |
| stat_ready | output | 1 | High when no switch is pending |

## Verification
The hardest case is a source write that arrives while a switch is still in flight. The slow source makes this window long: its enable takes two of its own 200 ns edges to open. The bench switches onto that source and writes a second code in the very next bus cycle. It then checks that the status ends on the first code. Period checks run only after a settle time longer than the divide-code synchroniser, so every measured period comes from a restarted counter.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CS_NSRC    = 4;
    localparam int CS_SEL_W   = 3;
    localparam int CS_DIV_W   = 4;
    localparam int CS_MAX_LOG = 9;
    localparam int CS_IDX_W   = $clog2(CS_NSRC);

    localparam logic [CS_SEL_W-1:0] CODE_HF_FAST = 3'b000;
    localparam logic [CS_SEL_W-1:0] CODE_HF_SLOW = 3'b110;
    localparam logic [CS_SEL_W-1:0] CODE_LF      = 3'b101;
    localparam logic [CS_SEL_W-1:0] CODE_EXT     = 3'b111;
    localparam logic [CS_SEL_W-1:0] CODE_AUX     = 3'b010;

    localparam logic [CS_DIV_W-1:0] RST_DIV_SLOW = 4'd6;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } sw_state_e;

    function automatic logic code_valid(input logic [CS_SEL_W-1:0] code);
        case (code)
            CODE_HF_FAST, CODE_HF_SLOW, CODE_LF, CODE_EXT, CODE_AUX: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [CS_IDX_W-1:0] code_idx(input logic [CS_SEL_W-1:0] code);
        case (code)
            CODE_LF:  return CS_IDX_W'(1);
            CODE_EXT: return CS_IDX_W'(2);
            CODE_AUX: return CS_IDX_W'(3);
            default:  return CS_IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/clksel_gate.sv
module clksel_gate (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    output logic gate_on,
    output logic clk_gated
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  gate_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = req;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // the gate only moves while the source clock is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= sync_q.s2;
    end

    assign gate_on   = gate_q;
    assign clk_gated = clk_src & gate_q;

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int NSRC  = CS_NSRC,
    parameter int SEL_W = CS_SEL_W,
    parameter int DIV_W = CS_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cfg_code,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    input  logic [NSRC-1:0]  ack,
    output logic [NSRC-1:0]  req,
    output logic             hold,
    output logic [SEL_W-1:0] stat_src,
    output logic [DIV_W-1:0] stat_div,
    output logic             stat_ready
);

    typedef struct packed {
        sw_state_e        st;
        logic [SEL_W-1:0] act;
        logic [SEL_W-1:0] tgt;
        logic [NSRC-1:0]  req;
        logic [DIV_W-1:0] div;
        logic             ready;
        logic [NSRC-1:0]  ack1;
        logic [NSRC-1:0]  ack2;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q, ctl_rst;
    logic [SEL_W-1:0] wr_code;
    logic [SEL_W-1:0] rst_code;
    logic             src_wr;

    assign wr_code = wr_data[SEL_W-1:0];
    assign src_wr  = wr_en && !wr_sel;

    always_comb begin
        rst_code      = code_valid(cfg_code) ? cfg_code : CODE_HF_FAST;
        ctl_rst       = '0;
        ctl_rst.st    = ST_RAISE;
        ctl_rst.act   = rst_code;
        ctl_rst.tgt   = rst_code;
        ctl_rst.req   = NSRC'(1) << code_idx(rst_code);
        ctl_rst.div   = (rst_code == CODE_HF_SLOW) ? RST_DIV_SLOW : '0;
        ctl_rst.ready = 1'b0;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ack1 = ack;
        ctl_d.ack2 = ctl_q.ack1;
        if (wr_en && wr_sel) ctl_d.div = wr_data;
        case (ctl_q.st)
            ST_RUN: begin
                if (src_wr && code_valid(wr_code) && (wr_code != ctl_q.act)) begin
                    ctl_d.req[code_idx(ctl_q.act)] = 1'b0;
                    ctl_d.tgt   = wr_code;
                    ctl_d.st    = ST_DROP;
                    ctl_d.ready = 1'b0;
                end
            end
            ST_DROP: begin
                if (!ctl_q.ack2[code_idx(ctl_q.act)]) begin
                    ctl_d.req[code_idx(ctl_q.tgt)] = 1'b1;
                    ctl_d.st = ST_RAISE;
                end
            end
            ST_RAISE: begin
                if (ctl_q.ack2[code_idx(ctl_q.tgt)]) begin
                    ctl_d.act   = ctl_q.tgt;
                    ctl_d.st    = ST_RUN;
                    ctl_d.ready = 1'b1;
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= ctl_rst;
        else        ctl_q <= ctl_d;
    end

    assign req        = ctl_q.req;
    assign hold       = (ctl_q.st == ST_RAISE);
    assign stat_src   = ctl_q.act;
    assign stat_div   = ctl_q.div;
    assign stat_ready = ctl_q.ready;

    // R6
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_q.req));

    // R6
    raise_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ctl_q.req & ~$past(ctl_q.req))) |-> ((ctl_q.ack2 & ~ctl_q.req) == '0));

    // R4
    ready_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.ready) |-> ctl_q.ack2[code_idx(ctl_q.act)]);

    // R5
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && !code_valid(wr_code)) |=> ($stable(ctl_q.act) && $stable(ctl_q.tgt)));

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && ctl_q.st != ST_RUN) |=> $stable(ctl_q.tgt));

endmodule

// File: rtl/clksel_postdiv.sv
module clksel_postdiv
    import clksel_pkg::*;
#(
    parameter int DIV_W   = CS_DIV_W,
    parameter int MAX_LOG = CS_MAX_LOG
) (
    input  logic             clk_in,
    input  logic             arst_n,
    input  logic [DIV_W-1:0] div_code,
    output logic             clk_out
);

    localparam int CNT_W = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;
    localparam int LG_W  = $clog2(MAX_LOG + 1);

    typedef struct packed {
        logic             run1;
        logic             run2;
        logic [DIV_W-1:0] d1;
        logic [DIV_W-1:0] d2;
        logic [DIV_W-1:0] dcur;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } pd_t;

    pd_t              pd_d, pd_q;
    logic [LG_W-1:0]  lg;
    logic [CNT_W-1:0] half_m1;
    logic             pass_q;

    function automatic logic [LG_W-1:0] clamp_log(input logic [DIV_W-1:0] code);
        if (code > DIV_W'(MAX_LOG)) return LG_W'(MAX_LOG);
        return LG_W'(code);
    endfunction

    always_comb begin
        lg      = clamp_log(pd_q.dcur);
        half_m1 = (lg == '0) ? '0 : CNT_W'((CNT_W'(1) << (lg - LG_W'(1))) - CNT_W'(1));
    end

    always_comb begin
        pd_d      = pd_q;
        pd_d.run1 = 1'b1;
        pd_d.run2 = pd_q.run1;
        pd_d.d1   = div_code;
        pd_d.d2   = pd_q.d1;
        if (!pd_q.run2) begin
            pd_d.cnt  = '0;
            pd_d.out  = 1'b0;
            pd_d.dcur = pd_q.d2;
        end else if (pd_q.d2 != pd_q.dcur) begin
            pd_d.dcur = pd_q.d2;
            pd_d.cnt  = '0;
            pd_d.out  = 1'b0;
        end else if (lg == '0) begin
            pd_d.cnt = '0;
            pd_d.out = 1'b0;
        end else if (pd_q.cnt == half_m1) begin
            pd_d.cnt = '0;
            pd_d.out = ~pd_q.out;
        end else begin
            pd_d.cnt = pd_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_in or negedge arst_n) begin
        if (!arst_n) pd_q <= '0;
        else         pd_q <= pd_d;
    end

    // pass-through enable moves only while the input clock is low
    always_ff @(negedge clk_in or negedge arst_n) begin
        if (!arst_n) pass_q <= 1'b0;
        else         pass_q <= pd_q.run2 && (lg == '0) && (pd_q.d2 == pd_q.dcur);
    end

    assign clk_out = pass_q ? clk_in : pd_q.out;

    // R8
    cnt_below_half_chk: assert property (@(posedge clk_in) disable iff (!arst_n)
        (lg != '0) |-> (pd_q.cnt <= half_m1));

    // R8
    restart_clears_chk: assert property (@(posedge clk_in) disable iff (!arst_n)
        (pd_q.run2 && pd_q.d2 != pd_q.dcur) |=> (pd_q.cnt == '0 && !pd_q.out));

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int NSRC    = CS_NSRC,
    parameter int SEL_W   = CS_SEL_W,
    parameter int DIV_W   = CS_DIV_W,
    parameter int MAX_LOG = CS_MAX_LOG
) (
    input  logic             clk_bus,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] cfg_rst_src,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    output logic             sys_clk,
    output logic [SEL_W-1:0] stat_src,
    output logic [DIV_W-1:0] stat_div,
    output logic             stat_ready
);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] gate_on;
    logic [NSRC-1:0] gated;
    logic            mux_clk;
    logic            hold;
    logic            pd_rst_n;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        clksel_gate u_gate (
            .clk_src   (src_clk[g]),
            .rst_n     (rst_n),
            .req       (req[g]),
            .gate_on   (gate_on[g]),
            .clk_gated (gated[g])
        );
    end

    assign mux_clk  = |gated;
    assign pd_rst_n = rst_n & ~hold;

    clksel_ctrl #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) u_ctrl (
        .clk        (clk_bus),
        .rst_n      (rst_n),
        .cfg_code   (cfg_rst_src),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ack        (gate_on),
        .req        (req),
        .hold       (hold),
        .stat_src   (stat_src),
        .stat_div   (stat_div),
        .stat_ready (stat_ready)
    );

    clksel_postdiv #(
        .DIV_W   (DIV_W),
        .MAX_LOG (MAX_LOG)
    ) u_postdiv (
        .clk_in   (mux_clk),
        .arst_n   (pd_rst_n),
        .div_code (stat_div),
        .clk_out  (sys_clk)
    );

    // R6
    one_gate_open_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $onehot0(gate_on));

    // R4
    ready_means_running_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        stat_ready |-> (gate_on != '0));

endmodule

// File: tb/clksel_top_tb.sv
`timescale 1ns/1ps
module clksel_top_tb;

    logic       clk_bus = 1'b0;
    logic       rst_n   = 1'b0;
    logic       c_hf = 1'b0, c_lf = 1'b0, c_ext = 1'b0, c_aux = 1'b0;
    logic [3:0] src_clk;
    logic [2:0] cfg_rst_src = 3'b110;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [3:0] wr_data = '0;
    logic       sys_clk;
    logic [2:0] stat_src;
    logic [3:0] stat_div;
    logic       stat_ready;

    always #5   clk_bus = ~clk_bus;
    always #4   c_hf    = ~c_hf;
    always #100 c_lf    = ~c_lf;
    always #15  c_ext   = ~c_ext;
    always #6   c_aux   = ~c_aux;
    assign src_clk = {c_aux, c_ext, c_lf, c_hf};

    clksel_top u_dut (
        .clk_bus     (clk_bus),
        .rst_n       (rst_n),
        .src_clk     (src_clk),
        .cfg_rst_src (cfg_rst_src),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .sys_clk     (sys_clk),
        .stat_src    (stat_src),
        .stat_div    (stat_div),
        .stat_ready  (stat_ready)
    );

    int checks = 0;
    int errors = 0;
    int pend   = 0;
    bit done   = 1'b0;

    typedef struct {
        longint exp_ns;
        string  tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit sel, input logic [3:0] data);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk_bus);
    endtask

    task automatic wait_ready();
        while (!stat_ready) @(negedge clk_bus);
        settle(60);
    endtask

    // driver side of the scoreboard
    task automatic expect_period(input longint exp_ns, input string tag);
        sb_q.push_back('{exp_ns, tag});
        pend++;
        wait (pend == 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            sb_item_t it;
            longint   t0, t1;
            wait (pend > 0);
            @(posedge sys_clk);
            @(posedge sys_clk); t0 = longint'($time);
            @(posedge sys_clk); t1 = longint'($time);
            it = sb_q.pop_front();
            check((t1 - t0) == it.exp_ns, it.tag, t1 - t0, it.exp_ns);
            pend--;
        end
    end

    task automatic do_reset(input logic [2:0] cfg);
        rst_n = 1'b0;
        cfg_rst_src = cfg;
        settle(5);
        check(stat_ready == 1'b0, "R1 ready low in reset", stat_ready, 0);
        rst_n = 1'b1;
        wait_ready();
    endtask

    initial begin
        // R1: strap 110, HF 8 ns, 1:64
        do_reset(3'b110);
        check(stat_src == 3'b110, "R1 reset src", stat_src, 3'b110);
        check(stat_div == 4'd6, "R1 reset div", stat_div, 6);
        expect_period(512, "R1 period 1:64");

        // R3 / R9: divide changes on HF
        bus_write(1'b1, 4'd0);
        check(stat_div == 4'd0, "R9 div visible next cycle", stat_div, 0);
        settle(60);
        expect_period(8, "R3 div 0");
        bus_write(1'b1, 4'd3);
        settle(60);
        expect_period(64, "R3 div 3");
        bus_write(1'b1, 4'd12);
        settle(60);
        expect_period(4096, "R3 div 12 clamps 512");

        // R4: switch to external source with 1:4
        bus_write(1'b1, 4'd2);
        bus_write(1'b0, 4'b0111);
        check(stat_ready == 1'b0, "R4 ready drops", stat_ready, 0);
        wait_ready();
        check(stat_src == 3'b111, "R4 src after switch", stat_src, 3'b111);
        expect_period(120, "R4 R5 ext period");

        // R5: invalid source code ignored
        bus_write(1'b0, 4'b0011);
        check(stat_ready == 1'b1, "R5 ready kept on bad code", stat_ready, 1);
        check(stat_src == 3'b111, "R5 src kept on bad code", stat_src, 3'b111);
        settle(60);
        expect_period(120, "R5 period kept on bad code");

        // R7: write during switch to slow source ignored
        bus_write(1'b1, 4'd0);
        bus_write(1'b0, 4'b0101);
        bus_write(1'b0, 4'b0010);
        wait_ready();
        check(stat_src == 3'b101, "R7 busy write ignored", stat_src, 3'b101);
        expect_period(200, "R5 R8 slow source period");

        // switch to auxiliary with 1:2
        bus_write(1'b1, 4'd1);
        bus_write(1'b0, 4'b0010);
        wait_ready();
        check(stat_src == 3'b010, "R4 src aux", stat_src, 3'b010);
        expect_period(24, "R5 R8 aux period");

        // R7: writing the active code starts no switch
        bus_write(1'b0, 4'b0010);
        check(stat_ready == 1'b1, "R7 same code no switch", stat_ready, 1);

        // R2: strap 000, then an invalid strap
        do_reset(3'b000);
        check(stat_src == 3'b000, "R2 strap 000 src", stat_src, 0);
        check(stat_div == 4'd0, "R2 strap 000 div", stat_div, 0);
        expect_period(8, "R2 strap 000 period");
        do_reset(3'b011);
        check(stat_src == 3'b000, "R2 invalid strap src", stat_src, 0);
        expect_period(8, "R2 invalid strap period");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_bus);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule